// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences an N-bit successive approximation conversion. A start pulse, accepted only while the block is idle, begins a binary search. The search resolves one code bit per clock cycle, from the most significant bit down to the least. A separate one-hot pointer register marks the bit under trial. Each cycle the block drives its working code to an external DAC. On the next clock edge it reads one comparator bit, which says whether the DAC output is above the sampled input. That bit decides whether the trial bit is kept or cleared.

The DAC, the comparator and the sample-and-hold are analog and lie outside this block. After the last decision the block copies the code to a result register and raises a done flag. The result register holds its value until the next conversion ends, so the previous result stays readable while a new search is running.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no start, `dac_code`, `result` and `done` are all zero.
- R2: A start pulse accepted while idle makes `dac_code` equal to half scale (only bit WIDTH-1 set) and `done` low on the next cycle.
- R3: If `cmp_hi` is 1 at the clock edge that ends a step, the bit under trial is cleared to 0. If `cmp_hi` is 0, that bit stays 1.
- R4: On every later step, `dac_code` has the next lower bit set to 1 and all bits below it 0. Every bit above the trial bit keeps its earlier decision.
- R5: `done` rises exactly WIDTH clock edges after the edge that accepted start, and the pointer moves down one bit position per edge.
- R6: With a comparator that reports `dac_code > vin` for an integer input `vin`, the final `result` equals `vin` for every value from 0 to 2^WIDTH-1.
- R7: `result` changes only at the edge of the least significant decision. It holds the previous conversion's value during a new conversion, and it holds after completion however `cmp_hi` moves.
- R8: A start pulse while a conversion is running is ignored: the search continues and finishes at the original time with the original result.
- R9: A start accepted after completion clears `done` on the next cycle and begins a new search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| cmp_hi | input | 1 | Comparator output: 1 when the DAC output is above the input |
| dac_code | output | WIDTH | Trial code driven to the DAC |
| result | output | WIDTH | Last completed conversion result |
| done | output | 1 | High from conversion end until the next accepted start |

## Verification
The embedded assertions check, on every cycle, the properties that depend only on local history. These are the half-scale load after an accepted start, the clear-or-keep decision on the bit under trial, the one-hot pointer stepping down one position, `done` following the last decision, and `result` holding at all other times. Two properties can only be shown by the bench's scenarios: that the full search converges on the input value, and that the timing stays intact under a mid-conversion start or a comparator that toggles after completion. The bench drives an ideal comparator from directed corner values and seeded random values, and compares the code at each step against the expected partial code.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] ptr, code, decided;
  logic             busy;

  assign busy     = |ptr;
  assign decided  = cmp_hi ? (code & ~ptr) : code;
  assign dac_code = code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      code   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else if (start && !busy) begin
      ptr  <= HALF;
      code <= HALF;
      done <= 1'b0;
    end else if (busy) begin
      ptr  <= ptr >> 1;
      code <= decided | (ptr >> 1);
      if (ptr[0]) begin
        result <= decided;
        done   <= 1'b1;
      end
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (dac_code == HALF && !done));

  // R3
  trial_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmp_hi) |=> ((dac_code & $past(ptr)) == '0));

  // R3
  trial_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp_hi) |=> ((dac_code & $past(ptr)) != '0));

  // R5
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(ptr) == 1));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr[0]) |=> (ptr == ($past(ptr) >> 1) && !done));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ptr[0]) |=> (done && !busy));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ptr[0]) |=> $stable(result));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ptr[0]) |=> busy);
endmodule

// File: tb/tb_sar_ctrl.sv
module tb_sar_ctrl;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_hi;
  logic [W-1:0] dac_code, result, vin = '0;
  logic done;
  int checks = 0, fails = 0;
  logic [W-1:0] prev_res = '0;
  logic finished = 1'b0;

  always #10 clk = ~clk;
  assign cmp_hi = dac_code > vin;

  sar_ctrl #(.WIDTH(W)) dut (.clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .result(result), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] step_code(input logic [W-1:0] v, input int pos);
    logic [W-1:0] hi_mask = ~((W'(1) << (pos + 1)) - W'(1));
    return (v & hi_mask) | (W'(1) << pos);
  endfunction

  task automatic convert(input logic [W-1:0] v, input int busy_start_at);
    vin = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(dac_code == (W'(1) << (W - 1)) && !done, "R2 R9", dac_code, 1 << (W - 1));
    for (int k = 0; k < W; k++) begin
      int pos = W - 1 - k;
      if (k > 0)
        chk(dac_code[pos + 1] == v[pos + 1], "R3", dac_code[pos + 1], v[pos + 1]);
      chk(dac_code == step_code(v, pos), "R4", dac_code, step_code(v, pos));
      chk(!done, "R5", done, 0);
      chk(result == prev_res, "R7", result, prev_res);
      if (k == busy_start_at) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    chk(done, "R5 R8", done, 1);
    chk(result == v, "R6", result, v);
    prev_res = v;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(dac_code == 0 && result == 0 && !done, "R1", dac_code | result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac_code == 0 && result == 0 && !done, "R1", dac_code | result, 0);

    convert('0, -1);
    convert(MAXV, -1);
    convert(W'(1) << (W - 1), -1);
    convert((W'(1) << (W - 1)) - W'(1), -1);
    convert(W'(1), -1);
    convert(W'(8'hA5), 2);
    convert(W'(8'h3C), 0);
    convert(W'(8'h7E), W - 1);

    vin = ~vin;
    repeat (5) begin
      @(negedge clk) vin = W'($urandom);
      chk(result == prev_res && done, "R7", result, prev_res);
    end

    for (int i = 0; i < 60; i++)
      convert(W'($urandom), (i % 4 == 0) ? int'($urandom % W) : -1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule